// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is a register-mapped general-purpose I/O port. A simple synchronous bus (word address, write strobe, write data, combinational read data) reaches a set of configuration and status registers. Pins sit in two banks of 32. For each pin, software picks whether the pin is driven by the port's own output register or by an external alternate-function source, and whether the pin drives at all.

The low 16 pins of the first bank also feed an interrupt unit. Each of those pins has three mode bits (edge, high, low) that together choose level-low, level-high, rising, falling or both-edge detection. It also has an enable bit, a sticky pending bit and a clear bit. Software clears a pending bit by writing its clear bit to 1 and then back to 0. The pending bits, masked by the enables, are ORed into one interrupt request line.

Pin inputs pass through a two-stage synchronizer before software reads them or the interrupt unit sees them.

Top module: `gpio_port`

## Requirements
- R1: After reset, every writable register reads 0, all pending bits are 0, `pad_oe` is all zero and `irq` is low.
- R2: With its select bit at 0, a pin drives `pad_oe` from its direction bit (1 = output) and `pad_out` from its output register bit.
- R3: With its select bit at 1, a pin takes `pad_out` from `alt_out` and `pad_oe` from `alt_oe` for that pin.
- R4: Pin n below 32 is bit n of the first bank's registers, and pin n of 32 or more is bit n-32 of the second bank's. The word addresses are: direction 0 (first bank) and 1 (second bank), select 2 and 3, output 4 and 5, input 6 and 7, edge 8, high 9, low 10, enable 11, clear 12, pending 13.
- R5: The input registers return `pin_in`. A change on `pin_in` is visible there after the second rising clock edge, and not after the first.
- R6: Each interrupt pin's mode comes from (edge, high, low). 001 is level low, 010 is level high, 110 is rising, 101 is falling, 111 is both edges, and 000 disables detection. The interrupt pins are pins 0 to 15.
- R7: In an edge mode, the chosen transition sets the pending bit on the third rising edge after the pin change, and the bit then stays set.
- R8: In a level mode, the pending bit is set on every cycle in which the level is present, even while the clear bit is held at 1.
- R9: While a clear bit is 1 in an edge mode, the pending bit reads 0 and edges on that pin are not recorded. Once the clear bit returns to 0, edges are recorded again.
- R10: A pending bit is recorded whatever its enable bit is, and the pending register returns the raw pending bits.
- R11: `irq` is high exactly when some pin has both its pending bit and its enable bit set.
- R12: Writes to read-only addresses (input, pending) have no effect, and unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pin_in | input | 64 | Pin levels from the pads |
| alt_out | input | 64 | Alternate-function output data |
| alt_oe | input | 64 | Alternate-function output enable |
| pad_out | output | 64 | Data driven to the pads |
| pad_oe | output | 64 | Pad output enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The interrupt properties assume that the synchronized pin value stays put between edges and that only the bus changes the mode, clear and enable bits. The stimulus therefore changes pins only at falling clock edges and holds each level for at least three cycles before it changes the pin again. The bench sets the mode bits while the interrupt pins are quiet, so that partly written modes cannot record spurious events. Every clear is done as a separate write of 1 and a later write of 0, which is how the clear register is meant to be used.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    // Order of the interrupt registers above the bank registers
    typedef enum logic [2:0] {
        IRQ_EDGE = 3'd0,
        IRQ_HIGH = 3'd1,
        IRQ_LOW  = 3'd2,
        IRQ_EN   = 3'd3,
        IRQ_CLR  = 3'd4,
        IRQ_PEND = 3'd5
    } irq_reg_e;

    localparam int IRQ_REG_COUNT = 6;
    localparam int IRQ_WR_COUNT  = 5;   // pending register is read-only

endpackage

// File: rtl/gpio_bank.sv
module gpio_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_dir,
    input  logic         wr_sel,
    input  logic         wr_out,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pin_in,
    input  logic [W-1:0] alt_out,
    input  logic [W-1:0] alt_oe,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] dir_o,
    output logic [W-1:0] sel_o,
    output logic [W-1:0] out_o,
    output logic [W-1:0] in_o
);

    typedef struct packed {
        logic [W-1:0] dir;
        logic [W-1:0] sel;
        logic [W-1:0] out;
        logic [W-1:0] meta;
        logic [W-1:0] sync;
    } bank_state_t;

    bank_state_t bank_d, bank_q;

    always_comb begin
        bank_d      = bank_q;
        bank_d.meta = pin_in;
        bank_d.sync = bank_q.meta;
        if (wr_dir) bank_d.dir = wdata;
        if (wr_sel) bank_d.sel = wdata;
        if (wr_out) bank_d.out = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    // Per-pin source mux: port registers or alternate function
    for (genvar i = 0; i < W; i++) begin : g_pin
        assign pad_out[i] = bank_q.sel[i] ? alt_out[i] : bank_q.out[i];
        assign pad_oe[i]  = bank_q.sel[i] ? alt_oe[i]  : bank_q.dir[i];
    end

    assign dir_o = bank_q.dir;
    assign sel_o = bank_q.sel;
    assign out_o = bank_q.out;
    assign in_o  = bank_q.sync;

    AST_OUT_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_out |=> (out_o == $past(wdata))); // R2

endmodule

// File: rtl/gpio_irq.sv
module gpio_irq
    import gpio_port_pkg::*;
#(
    parameter int N = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [IRQ_WR_COUNT-1:0] wr,
    input  logic [N-1:0]            wdata,
    input  logic [N-1:0]            lvl,
    output logic [N-1:0]            edge_o,
    output logic [N-1:0]            high_o,
    output logic [N-1:0]            low_o,
    output logic [N-1:0]            en_o,
    output logic [N-1:0]            clr_o,
    output logic [N-1:0]            pend_o,
    output logic                    irq
);

    typedef struct packed {
        logic [N-1:0] edg;
        logic [N-1:0] high;
        logic [N-1:0] low;
        logic [N-1:0] en;
        logic [N-1:0] clr;
        logic [N-1:0] pend;
        logic [N-1:0] prev;
    } irq_state_t;

    irq_state_t irq_d, irq_q;

    always_comb begin
        irq_d      = irq_q;
        irq_d.prev = lvl;
        if (wr[IRQ_EDGE]) irq_d.edg  = wdata;
        if (wr[IRQ_HIGH]) irq_d.high = wdata;
        if (wr[IRQ_LOW])  irq_d.low  = wdata;
        if (wr[IRQ_EN])   irq_d.en   = wdata;
        if (wr[IRQ_CLR])  irq_d.clr  = wdata;
        for (int i = 0; i < N; i++) begin
            logic lvl_hit, edg_hit;
            lvl_hit = !irq_q.edg[i] &&
                      ((irq_q.high[i] && lvl[i]) || (irq_q.low[i] && !lvl[i]));
            edg_hit = irq_q.edg[i] && !irq_q.clr[i] &&
                      ((irq_q.high[i] &&  lvl[i] && !irq_q.prev[i]) ||
                       (irq_q.low[i]  && !lvl[i] &&  irq_q.prev[i]));
            irq_d.pend[i] = (irq_q.pend[i] && !irq_q.clr[i]) || lvl_hit || edg_hit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign edge_o = irq_q.edg;
    assign high_o = irq_q.high;
    assign low_o  = irq_q.low;
    assign en_o   = irq_q.en;
    assign clr_o  = irq_q.clr;
    assign pend_o = irq_q.pend;
    assign irq    = |(irq_q.pend & irq_q.en);

    for (genvar i = 0; i < N; i++) begin : g_chk
        AST_EDGE_CLEAR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
            (edge_o[i] && clr_o[i]) |=> !pend_o[i]); // R9
        AST_LEVEL_KEEPS_SETTING: assert property (@(posedge clk) disable iff (!rst_n)
            (!edge_o[i] && high_o[i] && lvl[i]) |=> pend_o[i]); // R8
        AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_o[i] && !clr_o[i]) |=> pend_o[i]); // R7
    end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int BANK_W    = 32,
    parameter int NUM_BANKS = 2,
    parameter int IRQ_PINS  = 16,
    parameter int ADDR_W    = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic                          bus_we,
    input  logic [BANK_W-1:0]             bus_wdata,
    output logic [BANK_W-1:0]             bus_rdata,
    input  logic [NUM_BANKS*BANK_W-1:0]   pin_in,
    input  logic [NUM_BANKS*BANK_W-1:0]   alt_out,
    input  logic [NUM_BANKS*BANK_W-1:0]   alt_oe,
    output logic [NUM_BANKS*BANK_W-1:0]   pad_out,
    output logic [NUM_BANKS*BANK_W-1:0]   pad_oe,
    output logic                          irq
);

    localparam int DIR_BASE = 0;
    localparam int SEL_BASE = NUM_BANKS;
    localparam int OUT_BASE = 2 * NUM_BANKS;
    localparam int IN_BASE  = 3 * NUM_BANKS;
    localparam int IRQ_BASE = 4 * NUM_BANKS;

    logic [BANK_W-1:0] dir_rd [NUM_BANKS];
    logic [BANK_W-1:0] sel_rd [NUM_BANKS];
    logic [BANK_W-1:0] out_rd [NUM_BANKS];
    logic [BANK_W-1:0] in_rd  [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        gpio_bank #(.W(BANK_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_dir  (bus_we && (int'(bus_addr) == DIR_BASE + b)),
            .wr_sel  (bus_we && (int'(bus_addr) == SEL_BASE + b)),
            .wr_out  (bus_we && (int'(bus_addr) == OUT_BASE + b)),
            .wdata   (bus_wdata),
            .pin_in  (pin_in [b*BANK_W +: BANK_W]),
            .alt_out (alt_out[b*BANK_W +: BANK_W]),
            .alt_oe  (alt_oe [b*BANK_W +: BANK_W]),
            .pad_out (pad_out[b*BANK_W +: BANK_W]),
            .pad_oe  (pad_oe [b*BANK_W +: BANK_W]),
            .dir_o   (dir_rd[b]),
            .sel_o   (sel_rd[b]),
            .out_o   (out_rd[b]),
            .in_o    (in_rd[b])
        );
    end

    logic [IRQ_WR_COUNT-1:0] irq_wr;
    logic [IRQ_PINS-1:0]     irq_rd [IRQ_REG_COUNT];

    for (genvar k = 0; k < IRQ_WR_COUNT; k++) begin : g_irq_wr
        assign irq_wr[k] = bus_we && (int'(bus_addr) == IRQ_BASE + k);
    end

    gpio_irq #(.N(IRQ_PINS)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (irq_wr),
        .wdata  (bus_wdata[IRQ_PINS-1:0]),
        .lvl    (in_rd[0][IRQ_PINS-1:0]),
        .edge_o (irq_rd[IRQ_EDGE]),
        .high_o (irq_rd[IRQ_HIGH]),
        .low_o  (irq_rd[IRQ_LOW]),
        .en_o   (irq_rd[IRQ_EN]),
        .clr_o  (irq_rd[IRQ_CLR]),
        .pend_o (irq_rd[IRQ_PEND]),
        .irq    (irq)
    );

    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (int'(bus_addr) == DIR_BASE + b) bus_rdata = dir_rd[b];
            if (int'(bus_addr) == SEL_BASE + b) bus_rdata = sel_rd[b];
            if (int'(bus_addr) == OUT_BASE + b) bus_rdata = out_rd[b];
            if (int'(bus_addr) == IN_BASE  + b) bus_rdata = in_rd[b];
        end
        for (int k = 0; k < IRQ_REG_COUNT; k++) begin
            if (int'(bus_addr) == IRQ_BASE + k)
                bus_rdata = BANK_W'(irq_rd[k]);
        end
    end

    AST_IRQ_MASKED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (int'(bus_addr) == IRQ_BASE + int'(IRQ_EN)) &&
         (bus_wdata[IRQ_PINS-1:0] == '0)) |=> !irq); // R11

endmodule

// File: tb/gpio_port_test.sv
module gpio_port_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  bus_addr;
    logic        bus_we;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [63:0] pin_in;
    logic [63:0] alt_out;
    logic [63:0] alt_oe;
    logic [63:0] pad_out;
    logic [63:0] pad_oe;
    logic        irq;

    int tests  = 0;
    int failed = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .alt_out(alt_out), .alt_oe(alt_oe), .pad_out(pad_out),
        .pad_oe(pad_oe), .irq(irq)
    );

    // Scoreboard item: which output to look at, and the expected value
    typedef struct {
        int          sel;   // 0 read data, 1 irq, 2 pad_out, 3 pad_oe
        logic [63:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];

    // Monitor: compares one queued item after the next rising edge
    always @(posedge clk) begin
        if (sb_q.size() > 0) begin
            item_t       it;
            logic [63:0] got;
            #(CLK_PERIOD/4);
            it = sb_q.pop_front();
            case (it.sel)
                0:       got = {32'b0, bus_rdata};
                1:       got = {63'b0, irq};
                2:       got = pad_out;
                default: got = pad_oe;
            endcase
            tests++;
            if (got !== it.exp) begin
                failed++;
                $display("FAIL %s: actual %h expected %h", it.tag, got, it.exp);
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(int a, logic [31:0] d);
        bus_addr  = a[3:0];
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic expect_rd(int a, logic [63:0] e, string tag);
        item_t it;
        bus_addr = a[3:0];
        it.sel = 0; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic expect_sig(int s, logic [63:0] e, string tag);
        item_t it;
        it.sel = s; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failed++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, failed);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
        pin_in = '0; alt_out = '0; alt_oe = '0;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1: reset state
        for (int a = 0; a < 14; a++) expect_rd(a, 64'h0, "R1 register reset");
        expect_sig(3, 64'h0, "R1 pad_oe reset");
        expect_sig(1, 64'h0, "R1 irq reset");

        // R2: port-driven pins
        wr(0, 32'h0000_00F0);
        wr(4, 32'h0000_0050);
        expect_sig(3, 64'h0000_0000_0000_00F0, "R2 pad_oe from direction");
        expect_sig(2, 64'h0000_0000_0000_0050, "R2 pad_out from output reg");

        // R4: second bank, pin 35 = bit 3
        wr(1, 32'h0000_0008);
        wr(5, 32'h0000_0008);
        expect_sig(3, 64'h0000_0008_0000_00F0, "R4 pin 35 enable");
        expect_sig(2, 64'h0000_0008_0000_0050, "R4 pin 35 data");
        expect_rd(1, 64'h8, "R4 second bank direction readback");
        expect_rd(4, 64'h50, "R4 first bank output readback");

        // R3: alternate function on pins 0..7
        alt_out = 64'h0000_0000_0000_00A5;
        alt_oe  = 64'h0000_0000_0000_000F;
        wr(2, 32'h0000_00FF);
        expect_sig(2, 64'h0000_0008_0000_00A5, "R3 alternate data");
        expect_sig(3, 64'h0000_0008_0000_000F, "R3 alternate enable");
        expect_rd(2, 64'hFF, "R3 select readback");

        // R5: input path with two-stage latency
        pin_in = 64'h1234_5678_9ABC_DEF0;
        expect_rd(6, 64'h0, "R5 not visible after one edge");
        tick(1);
        expect_rd(6, 64'h9ABC_DEF0, "R5 first bank input");
        expect_rd(7, 64'h1234_5678, "R5 second bank input");
        pin_in = '0;
        tick(3);

        // R6: modes pin1 rising, pin2 falling, pin3 both, pin4 high, pin5 low
        pin_in[5] = 1'b1;
        tick(3);
        wr(8,  32'h0000_000E);
        wr(9,  32'h0000_001A);
        wr(10, 32'h0000_002C);
        expect_rd(8, 64'h0E, "R6 edge bits readback");
        expect_rd(13, 64'h0, "R6 no event while quiet");

        // R7: rising edges on 1,2,3
        pin_in[1] = 1'b1; pin_in[2] = 1'b1; pin_in[3] = 1'b1;
        tick(2);
        expect_rd(13, 64'h0A, "R7 rising and both-edge pins pend");
        pin_in[2] = 1'b0; pin_in[3] = 1'b0;
        tick(2);
        expect_rd(13, 64'h0E, "R7 falling edge pends, others sticky");

        // R10 / R11
        expect_sig(1, 64'h0, "R10 pending without enable keeps irq low");
        wr(11, 32'h0000_0002);
        expect_sig(1, 64'h1, "R11 enabled pending raises irq");

        // R9: clear held
        wr(12, 32'h0000_000E);
        expect_rd(13, 64'h0, "R9 clear empties pending");
        expect_sig(1, 64'h0, "R11 irq drops after clear");
        pin_in[1] = 1'b0;
        tick(2);
        expect_rd(13, 64'h0, "R9 edge during clear ignored");
        pin_in[1] = 1'b1;
        tick(2);
        expect_rd(13, 64'h0, "R9 rising during clear ignored");
        wr(12, 32'h0);
        expect_rd(13, 64'h0, "R9 release of clear records nothing");
        pin_in[1] = 1'b0;
        tick(3);
        pin_in[1] = 1'b1;
        tick(2);
        expect_rd(13, 64'h02, "R9 rearmed after clear released");
        expect_sig(1, 64'h1, "R11 irq from rearmed pin");

        // R8: level high survives a held clear
        pin_in[4] = 1'b1;
        tick(2);
        expect_rd(13, 64'h12, "R8 level high pends");
        wr(12, 32'h0000_0010);
        tick(1);
        expect_rd(13, 64'h12, "R8 level keeps pending under clear");
        pin_in[4] = 1'b0;
        tick(2);
        expect_rd(13, 64'h02, "R8 level gone, clear takes effect");
        wr(12, 32'h0);
        expect_rd(13, 64'h02, "R8 clear released");

        // R8 level low
        pin_in[5] = 1'b0;
        tick(2);
        expect_rd(13, 64'h22, "R8 level low pends");
        wr(11, 32'h0000_0020);
        expect_sig(1, 64'h1, "R11 level-low pin enabled");
        wr(11, 32'h0);
        expect_sig(1, 64'h0, "R11 all enables off");
        expect_rd(13, 64'h22, "R10 pending kept with enables off");

        // R12: read-only and unused addresses
        wr(13, 32'h0000_FFFF);
        expect_rd(13, 64'h22, "R12 pending write ignored");
        wr(6, 32'hFFFF_FFFF);
        expect_rd(6, 64'h02, "R12 input write ignored");
        expect_rd(15, 64'h0, "R12 unused address reads zero");

        tick(2);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

endmodule